// File: doc/BRIEF.md
# Address Range Access Monitor

The monitor observes a stream of memory transactions coming from a group of requester ports and reports any access that lands inside a protected address window. Several independent entries each hold a window given by an inclusive start and end word address. Each entry also holds a choice of which transaction directions to check, a flag that picks virtual or physical addresses, and a per-port arming mask. At most one transaction is offered per clock.

When a transaction qualifies for an entry, that entry's status latches an assert flag and records the ID of the offending port. The flag stays set until software clears it. The level interrupt output is the OR of all assert flags. Software programs and inspects the entries through a small 32-bit word-addressed register port. It clears a status by writing back the value it read, because bit 31 of a status write is write-one-to-clear. The block only observes and reports: it does not translate, arbitrate or block any traffic.

Register word address = {entry index, field}. Field 0 is the window start: bits [31:2] hold the start word, bit 0 enables read checking and bit 1 enables write checking. Field 1 is the window end: bits [31:2] hold the end word and bit 0 selects virtual (1) or physical (0). Field 2 is the port mask, one bit per port ID. Field 3 is the status: bit 31 is the assert flag and the low bits hold the captured port ID.

Top module: `addr_window_monitor`

## Requirements
- R1: After reset every register of every entry reads zero and `irq` is low.
- R2: Start, end and mask fields read back exactly what was written to their implemented bits; mask bits at or above the port count read as zero.
- R3: An access hits only when its word address is at least the start word and at most the end word; both bounds are inclusive.
- R4: A read (`txn_write`=0) is checked only when start bit 0 is set; a write (`txn_write`=1) is checked only when start bit 1 is set.
- R5: An access is checked by an entry only when `txn_virt` equals the entry's end bit 0.
- R6: An access is checked by an entry only when the mask bit indexed by `txn_port` is set; an entry whose mask is zero never fires.
- R7: On a qualifying access the entry's status reads back 0x8000_0000 OR the port ID, starting with the clock edge that sampled the access.
- R8: While the assert flag is set, later hits leave the captured port ID unchanged.
- R9: `irq` is the OR of all assert flags, registered, so it rises one clock after the status sets.
- R10: A status write with bit 31 set clears the flag and ID; with bit 31 clear it has no effect. If a clear and a hit happen in the same cycle, the hit wins and captures the new port.
- R11: Entries are independent; one access may set several entries at once.
- R12: With `txn_valid` low, no entry changes, whatever the other transaction inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; data appears on `reg_rdata` after the edge |
| reg_word_addr | input | REG_AW | Register word address {entry, field} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_word_addr | input | ADDR_W-2 | Word address of the transaction |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_virt | input | 1 | 1 = virtual address, 0 = physical |
| txn_port | input | PORT_ID_W | Requester port ID |
| irq | output | 1 | Level interrupt, OR of all assert flags |

## Verification
The bench targets the window edges: the first and last word inside each window and the words just outside them. A design with exclusive bounds or an off-by-one compare would miss hits at the edges or fire just outside them. It also crosses every qualifier in turn: direction enable, address space and port mask. Ignoring one of them makes an entry fire on traffic it should pass.

The sticky ID, the write-back clear and a clear landing in the same cycle as a new hit are each run. A design that overwrites the ID on each hit or lets the clear win would report the wrong port or lose a violation. The one-cycle lag of `irq` behind the status is also checked.

// File: rtl/awm_pkg.sv
package awm_pkg;

  localparam int unsigned REG_DATA_W = 32;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_MASK   = 2'd2,
    FLD_STATUS = 2'd3
  } awm_field_e;

  localparam int unsigned RDCHK_BIT  = 0;
  localparam int unsigned WRCHK_BIT  = 1;
  localparam int unsigned VIRT_BIT   = 0;
  localparam int unsigned ASSERT_BIT = 31;
  localparam int unsigned WADDR_LSB  = 2;

endpackage

// File: rtl/awm_cfg_regs.sv
module awm_cfg_regs
  import awm_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 3,
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned EIDX_W      = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [EIDX_W-1:0]                      wr_entry,
  input  awm_field_e                             wr_field,
  input  logic [REG_DATA_W-1:0]                  wr_data,
  output logic [NUM_ENTRIES-1:0][ADDR_W-3:0]     start_w,
  output logic [NUM_ENTRIES-1:0][ADDR_W-3:0]     end_w,
  output logic [NUM_ENTRIES-1:0]                 rd_chk,
  output logic [NUM_ENTRIES-1:0]                 wr_chk,
  output logic [NUM_ENTRIES-1:0]                 virt,
  output logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0]  mask
);

  localparam int unsigned WA_W = ADDR_W - 2;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_entry == EIDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        start_w[e] <= '0;
        end_w[e]   <= '0;
        rd_chk[e]  <= 1'b0;
        wr_chk[e]  <= 1'b0;
        virt[e]    <= 1'b0;
        mask[e]    <= '0;
      end else if (sel) begin
        case (wr_field)
          FLD_START: begin
            start_w[e] <= wr_data[WADDR_LSB +: WA_W];
            rd_chk[e]  <= wr_data[RDCHK_BIT];
            wr_chk[e]  <= wr_data[WRCHK_BIT];
          end
          FLD_END: begin
            end_w[e] <= wr_data[WADDR_LSB +: WA_W];
            virt[e]  <= wr_data[VIRT_BIT];
          end
          FLD_MASK: begin
            mask[e] <= wr_data[NUM_PORTS-1:0];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/awm_range_match.sv
module awm_range_match #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PORT_ID_W = 3
) (
  input  logic [ADDR_W-3:0]    start_w,
  input  logic [ADDR_W-3:0]    end_w,
  input  logic                 rd_chk,
  input  logic                 wr_chk,
  input  logic                 virt,
  input  logic [NUM_PORTS-1:0] mask,
  input  logic                 txn_valid,
  input  logic [ADDR_W-3:0]    txn_word_addr,
  input  logic                 txn_write,
  input  logic                 txn_virt,
  input  logic [PORT_ID_W-1:0] txn_port,
  output logic                 hit
);

  logic armed;
  logic dir_ok;
  logic space_ok;
  logic in_range;

  always_comb begin
    armed    = |(mask & (NUM_PORTS'(1) << txn_port));
    dir_ok   = txn_write ? wr_chk : rd_chk;
    space_ok = (txn_virt == virt);
    in_range = (txn_word_addr >= start_w) && (txn_word_addr <= end_w);
    hit      = txn_valid && armed && dir_ok && space_ok && in_range;
  end

endmodule

// File: rtl/awm_status_bank.sv
module awm_status_bank #(
  parameter int unsigned NUM_ENTRIES = 3,
  parameter int unsigned PORT_ID_W   = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_ENTRIES-1:0]                hit,
  input  logic [NUM_ENTRIES-1:0]                clr,
  input  logic [PORT_ID_W-1:0]                  port,
  output logic [NUM_ENTRIES-1:0]                st_assert,
  output logic [NUM_ENTRIES-1:0][PORT_ID_W-1:0] st_id,
  output logic                                  irq
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst) begin
        st_assert[e] <= 1'b0;
        st_id[e]     <= '0;
      end else if (hit[e] && (!st_assert[e] || clr[e])) begin
        st_assert[e] <= 1'b1;
        st_id[e]     <= port;
      end else if (clr[e]) begin
        st_assert[e] <= 1'b0;
        st_id[e]     <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |st_assert;
  end

endmodule

// File: rtl/addr_window_monitor.sv
module addr_window_monitor
  import awm_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 3,
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned REG_AW      = 6,
  parameter int unsigned PORT_ID_W   = $clog2(NUM_PORTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [REG_AW-1:0]     reg_word_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  txn_valid,
  input  logic [ADDR_W-3:0]     txn_word_addr,
  input  logic                  txn_write,
  input  logic                  txn_virt,
  input  logic [PORT_ID_W-1:0]  txn_port,
  output logic                  irq
);

  localparam int unsigned EIDX_W = REG_AW - 2;
  localparam int unsigned WA_W   = ADDR_W - 2;

  logic [EIDX_W-1:0] acc_entry;
  awm_field_e        acc_field;

  assign acc_entry = reg_word_addr[REG_AW-1:2];
  assign acc_field = awm_field_e'(reg_word_addr[1:0]);

  logic [NUM_ENTRIES-1:0][WA_W-1:0]      start_w;
  logic [NUM_ENTRIES-1:0][WA_W-1:0]      end_w;
  logic [NUM_ENTRIES-1:0]                rd_chk;
  logic [NUM_ENTRIES-1:0]                wr_chk;
  logic [NUM_ENTRIES-1:0]                virt;
  logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0] mask;
  logic [NUM_ENTRIES-1:0]                hit_vec;
  logic [NUM_ENTRIES-1:0]                clr_vec;
  logic [NUM_ENTRIES-1:0]                st_assert;
  logic [NUM_ENTRIES-1:0][PORT_ID_W-1:0] st_id;

  awm_cfg_regs #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_PORTS   (NUM_PORTS),
    .ADDR_W      (ADDR_W),
    .EIDX_W      (EIDX_W)
  ) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_entry (acc_entry),
    .wr_field (acc_field),
    .wr_data  (reg_wdata),
    .start_w  (start_w),
    .end_w    (end_w),
    .rd_chk   (rd_chk),
    .wr_chk   (wr_chk),
    .virt     (virt),
    .mask     (mask)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    awm_range_match #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .PORT_ID_W (PORT_ID_W)
    ) match_i (
      .start_w       (start_w[e]),
      .end_w         (end_w[e]),
      .rd_chk        (rd_chk[e]),
      .wr_chk        (wr_chk[e]),
      .virt          (virt[e]),
      .mask          (mask[e]),
      .txn_valid     (txn_valid),
      .txn_word_addr (txn_word_addr),
      .txn_write     (txn_write),
      .txn_virt      (txn_virt),
      .txn_port      (txn_port),
      .hit           (hit_vec[e])
    );

    assign clr_vec[e] = reg_wr_en && (acc_entry == EIDX_W'(e)) &&
                        (acc_field == FLD_STATUS) && reg_wdata[ASSERT_BIT];
  end

  awm_status_bank #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .PORT_ID_W   (PORT_ID_W)
  ) stat_i (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit_vec),
    .clr       (clr_vec),
    .port      (txn_port),
    .st_assert (st_assert),
    .st_id     (st_id),
    .irq       (irq)
  );

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (acc_entry == EIDX_W'(e)) begin
        case (acc_field)
          FLD_START: begin
            rd_mux[WADDR_LSB +: WA_W] = start_w[e];
            rd_mux[RDCHK_BIT]         = rd_chk[e];
            rd_mux[WRCHK_BIT]         = wr_chk[e];
          end
          FLD_END: begin
            rd_mux[WADDR_LSB +: WA_W] = end_w[e];
            rd_mux[VIRT_BIT]          = virt[e];
          end
          FLD_MASK: begin
            rd_mux[NUM_PORTS-1:0] = mask[e];
          end
          default: begin
            rd_mux[ASSERT_BIT]     = st_assert[e];
            rd_mux[PORT_ID_W-1:0]  = st_id[e];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/awm_checker.sv
module awm_checker #(
  parameter int unsigned NUM_ENTRIES = 3,
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned PORT_ID_W   = 3
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  irq,
  input logic [NUM_ENTRIES-1:0]                hit,
  input logic [NUM_ENTRIES-1:0]                clr,
  input logic [NUM_ENTRIES-1:0]                st_assert,
  input logic [NUM_ENTRIES-1:0][PORT_ID_W-1:0] st_id,
  input logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0] mask
);

  assert_irq_is_or_R9: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|st_assert));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
    assert_rise_from_hit_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(st_assert[e]) |-> $past(hit[e]));

    assert_free_entry_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      hit[e] |-> (mask[e] != '0));

    assert_sticky_id_R8: assert property (@(posedge clk) disable iff (rst)
      (st_assert[e] && $past(st_assert[e]) && !$past(clr[e])) |-> $stable(st_id[e]));

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
      ($past(clr[e]) && !$past(hit[e])) |-> !st_assert[e]);
  end

endmodule

bind addr_window_monitor awm_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .NUM_PORTS   (NUM_PORTS),
  .PORT_ID_W   (PORT_ID_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .hit       (hit_vec),
  .clr       (clr_vec),
  .st_assert (st_assert),
  .st_id     (st_id),
  .mask      (mask)
);

// File: tb/addr_window_monitor_tb_top.sv
module addr_window_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [5:0]  reg_word_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        txn_valid = 1'b0;
  logic [29:0] txn_word_addr = '0;
  logic        txn_write = 1'b0;
  logic        txn_virt = 1'b0;
  logic [2:0]  txn_port = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_window_monitor dut_i (
    .clk           (clk),
    .rst           (rst),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_en     (reg_rd_en),
    .reg_word_addr (reg_word_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .txn_valid     (txn_valid),
    .txn_word_addr (txn_word_addr),
    .txn_write     (txn_write),
    .txn_virt      (txn_virt),
    .txn_port      (txn_port),
    .irq           (irq)
  );

  // vector: [39:8] byte address, [7] write, [6] virtual, [5:3] port, [2:0] expected entry hits
  localparam int NVEC = 18;
  localparam logic [39:0] VEC [NVEC] = '{
    {32'h0000_1000, 1'b0, 1'b0, 3'd0, 3'b001},
    {32'h0000_10FC, 1'b1, 1'b0, 3'd3, 3'b001},
    {32'h0000_10F8, 1'b0, 1'b0, 3'd1, 3'b001},
    {32'h0000_1100, 1'b0, 1'b0, 3'd0, 3'b000},
    {32'h0000_0FFC, 1'b0, 1'b0, 3'd0, 3'b000},
    {32'h0000_1000, 1'b0, 1'b0, 3'd4, 3'b000},
    {32'h0000_1080, 1'b1, 1'b1, 3'd4, 3'b010},
    {32'h0000_1080, 1'b0, 1'b1, 3'd4, 3'b000},
    {32'h0000_1080, 1'b1, 1'b0, 3'd2, 3'b001},
    {32'h0000_1080, 1'b1, 1'b0, 3'd5, 3'b000},
    {32'h0000_2000, 1'b0, 1'b0, 3'd7, 3'b100},
    {32'h0000_2000, 1'b1, 1'b0, 3'd7, 3'b000},
    {32'h0000_2004, 1'b0, 1'b0, 3'd0, 3'b000},
    {32'h0000_1200, 1'b1, 1'b1, 3'd7, 3'b010},
    {32'h0000_1204, 1'b1, 1'b1, 3'd7, 3'b000},
    {32'h0000_107C, 1'b1, 1'b1, 3'd6, 3'b000},
    {32'h0000_2000, 1'b0, 1'b0, 3'd3, 3'b000},
    {32'h0000_2000, 1'b0, 1'b1, 3'd0, 3'b000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic reg_write(input int ent, input int fld, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en     = 1'b1;
    reg_word_addr = {4'(ent), 2'(fld)};
    reg_wdata     = data;
    @(negedge clk);
    reg_wr_en     = 1'b0;
  endtask

  task automatic reg_read(input int ent, input int fld, output logic [31:0] data);
    @(negedge clk);
    reg_rd_en     = 1'b1;
    reg_word_addr = {4'(ent), 2'(fld)};
    @(negedge clk);
    reg_rd_en     = 1'b0;
    data          = reg_rdata;
  endtask

  task automatic send(input logic [31:0] addr, input logic wr, input logic vt, input logic [2:0] port);
    @(negedge clk);
    txn_valid     = 1'b1;
    txn_word_addr = addr[31:2];
    txn_write     = wr;
    txn_virt      = vt;
    txn_port      = port;
    @(negedge clk);
    txn_valid     = 1'b0;
  endtask

  task automatic expect_reg(input string req, input int ent, input int fld, input logic [31:0] exp);
    logic [31:0] v;
    reg_read(ent, fld, v);
    check(req, v, exp);
  endtask

  task automatic clear_all();
    for (int e = 0; e < 3; e++) reg_write(e, 3, 32'h8000_0000);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int e = 0; e < 3; e++)
      for (int f = 0; f < 4; f++) expect_reg("R1 reg", e, f, 32'h0);

    // configuration and R2 readback
    reg_write(0, 0, 32'h0000_1003); reg_write(0, 1, 32'h0000_10FC); reg_write(0, 2, 32'h0000_000F);
    reg_write(1, 0, 32'h0000_1082); reg_write(1, 1, 32'h0000_1201); reg_write(1, 2, 32'h0000_00F0);
    reg_write(2, 0, 32'h0000_2001); reg_write(2, 1, 32'h0000_2000); reg_write(2, 2, 32'hFFFF_FF81);
    expect_reg("R2 start0", 0, 0, 32'h0000_1003);
    expect_reg("R2 end1",   1, 1, 32'h0000_1201);
    expect_reg("R2 mask2",  2, 2, 32'h0000_0081);
    expect_reg("R2 start1", 1, 0, 32'h0000_1082);

    // table walk: R3 bounds, R4 direction, R5 space, R6 mask, R7 capture, R9 irq
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] exp_hits;
      logic [2:0] port;
      exp_hits = VEC[i][2:0];
      port     = VEC[i][5:3];
      send(VEC[i][39:8], VEC[i][7], VEC[i][6], port);
      @(negedge clk);
      check($sformatf("R9 irq vec%0d", i), {31'b0, irq}, {31'b0, |exp_hits});
      for (int e = 0; e < 3; e++)
        expect_reg($sformatf("R3/R4/R5/R6/R7 vec%0d entry%0d", i, e), e, 3,
                   exp_hits[e] ? (32'h8000_0000 | 32'(port)) : 32'h0);
      clear_all();
    end

    // R11: overlapping entries both fire
    reg_write(1, 1, 32'h0000_1200);
    reg_write(1, 2, 32'h0000_00FF);
    send(32'h0000_10C0, 1'b1, 1'b0, 3'd1);
    expect_reg("R11 entry0", 0, 3, 32'h8000_0001);
    expect_reg("R11 entry1", 1, 3, 32'h8000_0001);
    expect_reg("R11 entry2", 2, 3, 32'h0);
    clear_all();

    // R8: sticky port ID
    send(32'h0000_1000, 1'b0, 1'b0, 3'd0);
    send(32'h0000_1004, 1'b0, 1'b0, 3'd2);
    expect_reg("R8 sticky id", 0, 3, 32'h8000_0000);

    // R10: write with bit31 clear does nothing
    reg_write(0, 3, 32'h0000_0007);
    expect_reg("R10 no-clear write", 0, 3, 32'h8000_0000);
    // R10: clear and hit in the same cycle, hit wins
    @(negedge clk);
    reg_wr_en = 1'b1; reg_word_addr = {4'd0, 2'd3}; reg_wdata = 32'h8000_0000;
    txn_valid = 1'b1; txn_word_addr = 30'h402; txn_write = 1'b0; txn_virt = 1'b0; txn_port = 3'd3;
    @(negedge clk);
    reg_wr_en = 1'b0; txn_valid = 1'b0;
    expect_reg("R10 hit beats clear", 0, 3, 32'h8000_0003);
    // R10: write back read value clears
    reg_read(0, 3, v);
    reg_write(0, 3, v);
    expect_reg("R10 write-back clear", 0, 3, 32'h0);
    @(negedge clk);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);

    // R9: one-cycle lag of irq behind status
    send(32'h0000_1000, 1'b0, 1'b0, 3'd1);
    check("R9 irq lag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq up", {31'b0, irq}, 32'h1);
    clear_all();

    // R12: valid low has no effect
    @(negedge clk);
    txn_valid = 1'b0; txn_word_addr = 30'h400; txn_write = 1'b0; txn_virt = 1'b0; txn_port = 3'd0;
    repeat (2) @(negedge clk);
    check("R12 irq", {31'b0, irq}, 32'h0);
    expect_reg("R12 status0", 0, 3, 32'h0);

    // R6: zero mask leaves entry free
    reg_write(0, 2, 32'h0);
    expect_reg("R6 mask zero", 0, 2, 32'h0);
    send(32'h0000_1000, 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    check("R6 irq", {31'b0, irq}, 32'h0);
    expect_reg("R6 status0", 0, 3, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule